// File: doc/BRIEF.md
# SDRAM clock-enable and command front end

This block is the input stage of a synchronous DRAM device model. On every rising clock edge it samples the clock-enable input, chip select, the row, column and write strobes, and the row/column and bank address. It keeps an internal clock-enable state. A low clock-enable sample suspends acceptance from the following edge and freezes the captured address. If every bank is idle on that edge, the block also enters power-down.

Each edge that is accepted is decoded into exactly one pulse on a one-hot command bus. The command bus is registered, so the pulse appears for one cycle after the edge. While the internal clock is suspended the command bus stays all zero. Bank state is supplied from outside as a single all-banks-idle input. The memory array and refresh timing live elsewhere.

Top module: `sdram_cmd_front`

## Requirements
- R1: All inputs are sampled only on the rising edge of `clk`. The outputs are registers that take the result of edge k and hold it until edge k+1.
- R2: On an accepted edge with `cs_n` low, the strobes (`ras_n`,`cas_n`,`we_n`) decode as follows. 111 gives NOP (bit 0), 000 gives mode register set (bit 2), 011 gives activate (bit 3), 101 gives read (bit 4), 100 gives write (bit 5), 010 gives precharge (bit 6) and 001 gives refresh (bit 7) of `cmd_onehot`.
- R3: On an accepted edge with `cs_n` high, `cmd_onehot` becomes deselect (bit 1) whatever the strobes are. `cmd_addr` and `cmd_bank` keep their previous values.
- R4: An edge is accepted only if `cke` was high at the previous edge. The edge on which `cke` is first sampled low is still accepted. `clk_en` shows the `cke` value taken at the last edge, that is, whether the next edge will be accepted.
- R5: On an edge that is not accepted, `cmd_onehot` becomes zero and `cmd_addr`/`cmd_bank` hold their values.
- R6: On every accepted edge exactly one bit of `cmd_onehot` is set.
- R7: If `cke` is sampled low on an accepted edge while `banks_idle` is high, `power_down` rises after that edge. It stays high while `cke` stays low, whatever `banks_idle` does. A low sample on an edge that is not accepted does not enter power-down.
- R8: A high `cke` sample clears `power_down` after that edge, and the next edge is accepted.
- R9: A synchronous high `rst` leaves `cmd_onehot`=0, `cmd_addr`=0, `cmd_bank`=0, `clk_en`=1 and `power_down`=0.
- R10: With `cs_n` low, the strobe pattern 110 (burst stop) decodes as NOP (bit 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock, rising edge used |
| rst | input | 1 | Synchronous reset, active high |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Row/column/mode address |
| ba | input | BANK_W | Bank address |
| banks_idle | input | 1 | High when every bank is idle |
| cmd_onehot | output | 8 | One-hot decoded command pulse |
| cmd_addr | output | ADDR_W | Address captured with the last command |
| cmd_bank | output | BANK_W | Bank captured with the last command |
| clk_en | output | 1 | Internal clock enable for the next edge |
| power_down | output | 1 | Power-down status |

## Verification
On the edge where `cke` first falls, two things happen together: a command is accepted and decoded, and power-down may be entered. The bench drives `cke` low together with a real command while `banks_idle` is high. It expects both the command pulse and `power_down` after that edge, and nothing decoded on the edge that follows. A second case drops `cke` while the banks are busy, then raises `banks_idle` during the suspension. This shows that power-down is decided only on the accepted edge.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;

    localparam int NUM_CMDS = 8;

    typedef enum logic [2:0] {
        CMD_NOP   = 3'd0,
        CMD_DESEL = 3'd1,
        CMD_MRS   = 3'd2,
        CMD_ACT   = 3'd3,
        CMD_READ  = 3'd4,
        CMD_WRITE = 3'd5,
        CMD_PRE   = 3'd6,
        CMD_REF   = 3'd7
    } cmd_idx_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } strobe_t;

    function automatic cmd_idx_e decode_strobes(input strobe_t s);
        cmd_idx_e c;
        if (s.cs_n) begin
            c = CMD_DESEL;
        end else begin
            case ({s.ras_n, s.cas_n, s.we_n})
                3'b000:  c = CMD_MRS;
                3'b011:  c = CMD_ACT;
                3'b101:  c = CMD_READ;
                3'b100:  c = CMD_WRITE;
                3'b010:  c = CMD_PRE;
                3'b001:  c = CMD_REF;
                default: c = CMD_NOP;   // 111 and burst stop 110
            endcase
        end
        return c;
    endfunction

    function automatic logic [NUM_CMDS-1:0] to_onehot(input cmd_idx_e c);
        logic [NUM_CMDS-1:0] v;
        v = '0;
        v[c] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/sdram_cke_gate.sv
module sdram_cke_gate (
    input  logic clk,
    input  logic rst,
    input  logic cke,
    input  logic banks_idle,
    output logic clk_en,
    output logic power_down
);

    logic cke_q;
    logic pd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cke_q <= 1'b1;
            pd_q  <= 1'b0;
        end else begin
            cke_q <= cke;
            if (cke) begin
                pd_q <= 1'b0;
            end else if (cke_q && banks_idle) begin
                pd_q <= 1'b1;
            end
        end
    end

    assign clk_en     = cke_q;
    assign power_down = pd_q;

    // R7: entry on an accepted falling sample with idle banks
    p_pd_entry_r7: assert property (@(posedge clk) disable iff (rst)
        (clk_en && !cke && banks_idle) |=> power_down);

    // R7: held while cke stays low
    p_pd_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (power_down && !cke) |=> power_down);

    // R8: a high sample leaves power-down and re-enables
    p_pd_exit_r8: assert property (@(posedge clk) disable iff (rst)
        cke |=> (!power_down && clk_en));

    // R7: never power-down without a suspended clock
    p_pd_implies_off_r7: assert property (@(posedge clk) disable iff (rst)
        power_down |-> !clk_en);

endmodule

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
    import sdram_cmd_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int BANK_W = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                accept,
    input  strobe_t             strobes,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [BANK_W-1:0]   ba,
    output logic [NUM_CMDS-1:0] cmd_onehot,
    output logic [ADDR_W-1:0]   cmd_addr,
    output logic [BANK_W-1:0]   cmd_bank
);

    cmd_idx_e            dec;
    logic [NUM_CMDS-1:0] cmd_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [BANK_W-1:0]   bank_q;
    logic                latch_addr;

    always_comb begin
        dec        = decode_strobes(strobes);
        latch_addr = accept && !strobes.cs_n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            addr_q <= '0;
            bank_q <= '0;
        end else begin
            cmd_q <= accept ? to_onehot(dec) : '0;
            if (latch_addr) begin
                addr_q <= addr;
                bank_q <= ba;
            end
        end
    end

    assign cmd_onehot = cmd_q;
    assign cmd_addr   = addr_q;
    assign cmd_bank   = bank_q;

    // R6: exactly one pulse per accepted edge
    p_one_cmd_r6: assert property (@(posedge clk) disable iff (rst)
        accept |=> ($countones(cmd_onehot) == 1));

    // R5: silence and frozen address on refused edges
    p_mute_r5: assert property (@(posedge clk) disable iff (rst)
        !accept |=> (cmd_onehot == '0 && $stable(cmd_addr) && $stable(cmd_bank)));

    // R3: deselect leaves the captured address alone
    p_desel_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (accept && strobes.cs_n) |=> ($stable(cmd_addr) && cmd_onehot[CMD_DESEL]));

endmodule

// File: rtl/sdram_cmd_front.sv
module sdram_cmd_front
    import sdram_cmd_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int BANK_W = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cke,
    input  logic                cs_n,
    input  logic                ras_n,
    input  logic                cas_n,
    input  logic                we_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [BANK_W-1:0]   ba,
    input  logic                banks_idle,
    output logic [NUM_CMDS-1:0] cmd_onehot,
    output logic [ADDR_W-1:0]   cmd_addr,
    output logic [BANK_W-1:0]   cmd_bank,
    output logic                clk_en,
    output logic                power_down
);

    strobe_t strobes;

    always_comb begin
        strobes.cs_n  = cs_n;
        strobes.ras_n = ras_n;
        strobes.cas_n = cas_n;
        strobes.we_n  = we_n;
    end

    sdram_cke_gate u_gate (
        .clk        (clk),
        .rst        (rst),
        .cke        (cke),
        .banks_idle (banks_idle),
        .clk_en     (clk_en),
        .power_down (power_down)
    );

    sdram_cmd_decode #(
        .ADDR_W (ADDR_W),
        .BANK_W (BANK_W)
    ) u_dec (
        .clk        (clk),
        .rst        (rst),
        .accept     (clk_en),
        .strobes    (strobes),
        .addr       (addr),
        .ba         (ba),
        .cmd_onehot (cmd_onehot),
        .cmd_addr   (cmd_addr),
        .cmd_bank   (cmd_bank)
    );

    // R4: a low sample on an accepted edge still yields a command, then silence
    p_fall_edge_r4: assert property (@(posedge clk) disable iff (rst)
        (clk_en && !cke) |=> (!clk_en && $onehot(cmd_onehot)));

    // R2: mode register set comes only from an all-low selected pattern
    p_mrs_src_r2: assert property (@(posedge clk) disable iff (rst)
        (clk_en && !cs_n && !ras_n && !cas_n && !we_n) |=> cmd_onehot[CMD_MRS]);

endmodule

// File: tb/sdram_cmd_front_tb.sv
module sdram_cmd_front_tb;

    localparam int ADDR_W = 13;
    localparam int BANK_W = 2;

    logic              clk = 1'b0;
    logic              rst;
    logic              cke, cs_n, ras_n, cas_n, we_n, banks_idle;
    logic [ADDR_W-1:0] addr;
    logic [BANK_W-1:0] ba;
    logic [7:0]        cmd_onehot;
    logic [ADDR_W-1:0] cmd_addr;
    logic [BANK_W-1:0] cmd_bank;
    logic              clk_en, power_down;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    sdram_cmd_front #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_dut (
        .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .addr(addr), .ba(ba),
        .banks_idle(banks_idle), .cmd_onehot(cmd_onehot),
        .cmd_addr(cmd_addr), .cmd_bank(cmd_bank), .clk_en(clk_en),
        .power_down(power_down)
    );

    typedef struct packed {
        logic       cke;
        logic       cs_n;
        logic       ras_n;
        logic       cas_n;
        logic       we_n;
        logic       idle;
        logic [3:0] a;
        logic [7:0] exp_cmd;
        logic       exp_en;
        logic       exp_pd;
        logic [3:0] exp_a;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        //  cke cs  ras cas we  idle a     cmd     en  pd  ea
        '{1'b1,1'b0,1'b1,1'b1,1'b1,1'b0,4'h1,8'h01,1'b1,1'b0,4'h1}, // R2 NOP
        '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,4'h2,8'h02,1'b1,1'b0,4'h1}, // R3 deselect
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,4'h3,8'h04,1'b1,1'b0,4'h3}, // R2 MRS
        '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,4'h4,8'h08,1'b1,1'b0,4'h4}, // R2 ACT
        '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,4'h5,8'h10,1'b1,1'b0,4'h5}, // R2 READ
        '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,4'h6,8'h20,1'b1,1'b0,4'h6}, // R2 WRITE
        '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,4'h7,8'h40,1'b1,1'b0,4'h7}, // R2 PRE
        '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,4'h8,8'h80,1'b1,1'b0,4'h8}, // R2 REF
        '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,4'h9,8'h01,1'b1,1'b0,4'h9}, // R10 burst stop
        '{1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,4'hA,8'h08,1'b0,1'b0,4'hA}, // R4 falling edge accepted
        '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,4'hB,8'h00,1'b0,1'b0,4'hA}, // R5 R7 suspended, no pd
        '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,4'hC,8'h00,1'b1,1'b0,4'hA}, // R4 still refused
        '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,4'hD,8'h40,1'b1,1'b0,4'hD}, // R4 resumed
        '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,4'hE,8'h01,1'b0,1'b1,4'hE}, // R7 pd entry
        '{1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,4'hF,8'h00,1'b0,1'b1,4'hE}, // R7 pd held
        '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,4'h1,8'h00,1'b1,1'b0,4'hE}, // R8 exit edge
        '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,4'h2,8'h10,1'b1,1'b0,4'h2}, // R8 accepted
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,4'h3,8'h04,1'b0,1'b1,4'h3}, // R4 R7 same cycle
        '{1'b1,1'b1,1'b1,1'b1,1'b1,1'b0,4'h4,8'h00,1'b1,1'b0,4'h3}, // R8 exit
        '{1'b1,1'b0,1'b1,1'b1,1'b1,1'b0,4'h5,8'h01,1'b1,1'b0,4'h5}  // R2 NOP again
    };

    task automatic drive(input logic k, input logic c, input logic r,
                         input logic s, input logic w, input logic i,
                         input logic [3:0] a);
        cke = k; cs_n = c; ras_n = r; cas_n = s; we_n = w; banks_idle = i;
        addr = {{(ADDR_W-4){1'b0}}, a};
        ba   = a[BANK_W-1:0];
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        rst = 1'b1;
        drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 4'h0);
        step();
        step();
        // R9 reset state
        check("R9 cmd",  32'(cmd_onehot), 32'h0);
        check("R9 addr", 32'(cmd_addr),   32'h0);
        check("R9 en",   32'(clk_en),     32'h1);
        check("R9 pd",   32'(power_down), 32'h0);
        rst = 1'b0;

        // R1: outputs change only after the sampling edge
        drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'h7);
        #2;
        check("R1 no change before edge", 32'(cmd_onehot), 32'h0);
        step();
        check("R1 act after edge", 32'(cmd_onehot), 32'h08);

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].cke, VECS[i].cs_n, VECS[i].ras_n, VECS[i].cas_n,
                  VECS[i].we_n, VECS[i].idle, VECS[i].a);
            step();
            check($sformatf("R2/R3/R6/R10 cmd vec%0d", i), 32'(cmd_onehot), 32'(VECS[i].exp_cmd));
            check($sformatf("R4 en vec%0d", i),           32'(clk_en),     32'(VECS[i].exp_en));
            check($sformatf("R7/R8 pd vec%0d", i),        32'(power_down), 32'(VECS[i].exp_pd));
            check($sformatf("R3/R5 addr vec%0d", i),      32'(cmd_addr),   32'(VECS[i].exp_a));
        end

        // R9: reset while in power-down
        drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'h6);
        step();
        check("R7 pd before reset", 32'(power_down), 32'h1);
        rst = 1'b1;
        step();
        check("R9 pd cleared", 32'(power_down), 32'h0);
        check("R9 en set",     32'(clk_en),     32'h1);
        check("R9 addr",       32'(cmd_addr),   32'h0);
        rst = 1'b0;

        // R4: first edge after reset is accepted even with cke low
        drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'h9);
        step();
        check("R4 read on low edge", 32'(cmd_onehot), 32'h10);
        check("R5 bank captured",    32'(cmd_bank),   32'h1);
        drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'h2);
        step();
        check("R5 frozen bank", 32'(cmd_bank),   32'h1);
        check("R5 silent",      32'(cmd_onehot), 32'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog (R1..all) actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule